// File: doc/BRIEF.md
# Software-Filled Set-Associative TLB

This block is a small set-associative translation lookaside buffer whose contents are managed only by software. The lookup port takes a virtual address and an access type (read or write). In the same cycle it reports whether the address hit, which way matched, the physical address, and the attribute bits stored with the page. It also flags a hit on more than one way, and flags a write to a page whose dirty bit is still clear.

Refills never come from hardware. Software first writes a tag-side staging register holding the virtual page number. It then writes a data-side staging register holding the physical page number, the two protection bits, and the size, cacheable, dirty, shared and valid bits. A load command then copies both staging registers into the entry picked by the set index and by a replacement-way field. Software can write that field directly. Fault logic can also preload it with the way that caused a fault, so that a handler can refill the same way without computing it.

The default geometry is four ways of 32 sets, 4 KB pages and a 32-bit virtual address. All of these are parameters.

Top module: `sw_fill_tlb`

## Requirements
- R1: After reset every entry is invalid and the replacement-way field reads 0, so no lookup hits until a load with the valid bit set has taken effect.
- R2: The virtual page number is VA[31:12]. The set index is VPN[4:0] and the stored tag is VPN[19:5]. An entry in the same set with a different tag does not match.
- R3: A lookup hits only if the tag matches and the entry's valid bit is 1. A load whose staged valid bit is 0 leaves that entry unable to hit.
- R4: A load command changes the entry at the next rising clock edge. A lookup made in the same cycle as the load sees the old contents.
- R5: A load writes the way held in the replacement-way field before that edge.
- R6: A software write to the replacement-way field sets it at the next edge. So does a fault preload. If both occur in the same cycle, the software value is kept.
- R7: When neither a software write nor a fault preload is present, the replacement-way field keeps its value.
- R8: On a hit, lk_pa equals {PPN, VA[11:0]}, and the protection, size, cacheable, dirty and shared outputs equal the loaded values. On a miss these outputs are 0.
- R9: When several ways match, lk_way is the lowest-numbered matching way and lk_multi is 1. lk_multi is 0 for a single hit or a miss.
- R10: lk_dirty_fault is 1 exactly when the lookup hits, lk_write is 1 and the entry's dirty bit is 0.
- R11: A load copies the staging registers as they were before its edge. A staging write in the same cycle as the load affects only later loads.
- R12: All four ways of one set hold distinct entries at once. Reloading one way replaces only that way's entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| stg_tag_we | input | 1 | Write strobe for the tag-side staging register |
| stg_tag_vpn | input | VPN_W | Virtual page number to stage |
| stg_data_we | input | 1 | Write strobe for the data-side staging register |
| stg_data_ppn | input | PPN_W | Physical page number to stage |
| stg_data_prot | input | 2 | Protection bits to stage |
| stg_data_size | input | 1 | Page size bit to stage (stored only) |
| stg_data_cache | input | 1 | Cacheable bit to stage |
| stg_data_dirty | input | 1 | Dirty bit to stage |
| stg_data_share | input | 1 | Shared bit to stage |
| stg_data_valid | input | 1 | Valid bit to stage |
| repl_wr_en | input | 1 | Software write of the replacement-way field |
| repl_wr_way | input | WAY_W | Value for the software write |
| fault_set | input | 1 | Fault logic preload of the replacement-way field |
| fault_way | input | WAY_W | Way that caused the fault |
| repl_way | output | WAY_W | Current replacement-way field |
| load_cmd | input | 1 | Copy the staging registers into the TLB |
| lk_va | input | VA_W | Lookup virtual address |
| lk_write | input | 1 | Lookup access type, 1 for write |
| lk_hit | output | 1 | Lookup hit |
| lk_way | output | WAY_W | Matching way (lowest if several) |
| lk_multi | output | 1 | More than one way matched |
| lk_pa | output | PPN_W+PAGE_BITS | Translated physical address |
| lk_prot | output | 2 | Protection bits of the hit entry |
| lk_size | output | 1 | Size bit of the hit entry |
| lk_cache | output | 1 | Cacheable bit of the hit entry |
| lk_dirty | output | 1 | Dirty bit of the hit entry |
| lk_share | output | 1 | Shared bit of the hit entry |
| lk_dirty_fault | output | 1 | Write hit on a page whose dirty bit is clear |

## Verification
The assertions check several rules on every cycle: hit agrees with the per-way match vector, the multi-hit flag and the lowest-way choice, the dirty-fault condition, the update and hold rules of the replacement-way field, and that a valid load is visible in the following cycle in the way the field named. Only the bench scenarios can show the translated address and stored attributes coming back intact. They also show the index/tag split separating pages, that a same-cycle lookup sees old contents, that a staging write racing a load does not leak into it, and that refilling one way leaves its neighbours untouched.

// File: rtl/sw_fill_tlb_pkg.sv
package sw_fill_tlb_pkg;
   localparam int PROT_W = 2;

   // attribute bits stored with each entry, valid kept separately
   typedef struct packed {
      logic [PROT_W-1:0] prot;
      logic              size;
      logic              cache;
      logic              dirty;
      logic              share;
   } tlb_flags_t;

   localparam int FLAGS_W = $bits(tlb_flags_t);
endpackage

// File: rtl/sw_fill_tlb_stage.sv
module sw_fill_tlb_stage
   import sw_fill_tlb_pkg::*;
#(
   parameter int VPN_W = 20,
   parameter int PPN_W = 20,
   parameter int WAY_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tag_we,
   input  logic [VPN_W-1:0] tag_vpn,
   input  logic             data_we,
   input  logic [PPN_W-1:0] data_ppn,
   input  tlb_flags_t       data_flags,
   input  logic             data_valid,
   input  logic             repl_we,
   input  logic [WAY_W-1:0] repl_wdata,
   input  logic             fault_set,
   input  logic [WAY_W-1:0] fault_way,
   output logic [VPN_W-1:0] stage_vpn,
   output logic [PPN_W-1:0] stage_ppn,
   output tlb_flags_t       stage_flags,
   output logic             stage_valid,
   output logic [WAY_W-1:0] repl_way
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_vpn <= '0;
      end else if (tag_we) begin
         stage_vpn <= tag_vpn;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_ppn   <= '0;
         stage_flags <= '0;
         stage_valid <= 1'b0;
      end else if (data_we) begin
         stage_ppn   <= data_ppn;
         stage_flags <= data_flags;
         stage_valid <= data_valid;
      end
   end

   // software write has priority over the fault preload
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         repl_way <= '0;
      end else if (repl_we) begin
         repl_way <= repl_wdata;
      end else if (fault_set) begin
         repl_way <= fault_way;
      end
   end

endmodule

// File: rtl/sw_fill_tlb_bank.sv
module sw_fill_tlb_bank
   import sw_fill_tlb_pkg::*;
#(
   parameter int SETS  = 32,
   parameter int IDX_W = 5,
   parameter int TAG_W = 15,
   parameter int PPN_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [PPN_W-1:0] wr_ppn,
   input  tlb_flags_t       wr_flags,
   input  logic             wr_valid,
   input  logic [IDX_W-1:0] rd_idx,
   input  logic [TAG_W-1:0] rd_tag,
   output logic             match,
   output logic [PPN_W-1:0] rd_ppn,
   output tlb_flags_t       rd_flags
);

   logic [SETS-1:0]  valid_q;
   logic [TAG_W-1:0] tag_q   [SETS];
   logic [PPN_W-1:0] ppn_q   [SETS];
   tlb_flags_t       flags_q [SETS];

   // only the valid bits need a reset value
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else if (wr_en) begin
         valid_q[wr_idx] <= wr_valid;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_idx]   <= wr_tag;
         ppn_q[wr_idx]   <= wr_ppn;
         flags_q[wr_idx] <= wr_flags;
      end
   end

   assign match    = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
   assign rd_ppn   = ppn_q[rd_idx];
   assign rd_flags = flags_q[rd_idx];

endmodule

// File: rtl/sw_fill_tlb_select.sv
module sw_fill_tlb_select
   import sw_fill_tlb_pkg::*;
#(
   parameter int WAYS  = 4,
   parameter int WAY_W = 2,
   parameter int PPN_W = 20
) (
   input  logic [WAYS-1:0]             hit_vec,
   input  logic [WAYS-1:0][PPN_W-1:0]  ppn_vec,
   input  tlb_flags_t [WAYS-1:0]       flags_vec,
   output logic                        hit,
   output logic [WAY_W-1:0]            way,
   output logic                        multi,
   output logic [PPN_W-1:0]            ppn,
   output tlb_flags_t                  flags
);

   logic [WAYS-1:0] below_mask;

   // scan from the top down so the lowest matching way wins
   always_comb begin
      way   = '0;
      ppn   = '0;
      flags = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (hit_vec[w]) begin
            way   = WAY_W'(w);
            ppn   = ppn_vec[w];
            flags = flags_vec[w];
         end
      end
   end

   assign hit        = |hit_vec;
   assign below_mask = hit_vec - {{(WAYS-1){1'b0}}, 1'b1};
   assign multi      = |(hit_vec & below_mask);

endmodule

// File: rtl/sw_fill_tlb.sv
module sw_fill_tlb
   import sw_fill_tlb_pkg::*;
#(
   parameter  int VA_W      = 32,
   parameter  int PAGE_BITS = 12,
   parameter  int WAYS      = 4,
   parameter  int SETS      = 32,
   parameter  int PPN_W     = 20,
   localparam int VPN_W     = VA_W - PAGE_BITS,
   localparam int IDX_W     = $clog2(SETS),
   localparam int TAG_W     = VPN_W - IDX_W,
   localparam int WAY_W     = $clog2(WAYS),
   localparam int PA_W      = PPN_W + PAGE_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stg_tag_we,
   input  logic [VPN_W-1:0]  stg_tag_vpn,
   input  logic              stg_data_we,
   input  logic [PPN_W-1:0]  stg_data_ppn,
   input  logic [PROT_W-1:0] stg_data_prot,
   input  logic              stg_data_size,
   input  logic              stg_data_cache,
   input  logic              stg_data_dirty,
   input  logic              stg_data_share,
   input  logic              stg_data_valid,
   input  logic              repl_wr_en,
   input  logic [WAY_W-1:0]  repl_wr_way,
   input  logic              fault_set,
   input  logic [WAY_W-1:0]  fault_way,
   output logic [WAY_W-1:0]  repl_way,
   input  logic              load_cmd,
   input  logic [VA_W-1:0]   lk_va,
   input  logic              lk_write,
   output logic              lk_hit,
   output logic [WAY_W-1:0]  lk_way,
   output logic              lk_multi,
   output logic [PA_W-1:0]   lk_pa,
   output logic [PROT_W-1:0] lk_prot,
   output logic              lk_size,
   output logic              lk_cache,
   output logic              lk_dirty,
   output logic              lk_share,
   output logic              lk_dirty_fault
);

   // elaboration-time parameter checks
   if (WAYS < 2 || (1 << WAY_W) != WAYS) begin : g_bad_ways
      $error("WAYS must be a power of two of at least 2");
   end
   if (SETS < 2 || (1 << IDX_W) != SETS) begin : g_bad_sets
      $error("SETS must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("set index leaves no tag bits");
   end
   if (PAGE_BITS < 1 || PAGE_BITS >= VA_W) begin : g_bad_page
      $error("PAGE_BITS out of range");
   end

   logic [VPN_W-1:0] stage_vpn;
   logic [PPN_W-1:0] stage_ppn;
   tlb_flags_t       stage_flags;
   logic             stage_valid;
   tlb_flags_t       stg_flags_in;

   assign stg_flags_in = '{prot:  stg_data_prot,
                           size:  stg_data_size,
                           cache: stg_data_cache,
                           dirty: stg_data_dirty,
                           share: stg_data_share};

   sw_fill_tlb_stage #(
      .VPN_W (VPN_W),
      .PPN_W (PPN_W),
      .WAY_W (WAY_W)
   ) u_stage (
      .clk         (clk),
      .rst_n       (rst_n),
      .tag_we      (stg_tag_we),
      .tag_vpn     (stg_tag_vpn),
      .data_we     (stg_data_we),
      .data_ppn    (stg_data_ppn),
      .data_flags  (stg_flags_in),
      .data_valid  (stg_data_valid),
      .repl_we     (repl_wr_en),
      .repl_wdata  (repl_wr_way),
      .fault_set   (fault_set),
      .fault_way   (fault_way),
      .stage_vpn   (stage_vpn),
      .stage_ppn   (stage_ppn),
      .stage_flags (stage_flags),
      .stage_valid (stage_valid),
      .repl_way    (repl_way)
   );

   logic [VPN_W-1:0] lk_vpn;
   logic [IDX_W-1:0] lk_idx;
   logic [TAG_W-1:0] lk_tag;
   logic [IDX_W-1:0] wr_idx;
   logic [TAG_W-1:0] wr_tag;

   assign lk_vpn = lk_va[VA_W-1:PAGE_BITS];
   assign lk_idx = lk_vpn[IDX_W-1:0];
   assign lk_tag = lk_vpn[VPN_W-1:IDX_W];
   assign wr_idx = stage_vpn[IDX_W-1:0];
   assign wr_tag = stage_vpn[VPN_W-1:IDX_W];

   logic [WAYS-1:0]            hit_vec;
   logic [WAYS-1:0][PPN_W-1:0] ppn_vec;
   tlb_flags_t [WAYS-1:0]      flags_vec;

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic way_wr;
      assign way_wr = load_cmd && (repl_way == WAY_W'(w));

      sw_fill_tlb_bank #(
         .SETS  (SETS),
         .IDX_W (IDX_W),
         .TAG_W (TAG_W),
         .PPN_W (PPN_W)
      ) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (way_wr),
         .wr_idx   (wr_idx),
         .wr_tag   (wr_tag),
         .wr_ppn   (stage_ppn),
         .wr_flags (stage_flags),
         .wr_valid (stage_valid),
         .rd_idx   (lk_idx),
         .rd_tag   (lk_tag),
         .match    (hit_vec[w]),
         .rd_ppn   (ppn_vec[w]),
         .rd_flags (flags_vec[w])
      );
   end

   logic [PPN_W-1:0] sel_ppn;
   tlb_flags_t       sel_flags;

   sw_fill_tlb_select #(
      .WAYS  (WAYS),
      .WAY_W (WAY_W),
      .PPN_W (PPN_W)
   ) u_select (
      .hit_vec   (hit_vec),
      .ppn_vec   (ppn_vec),
      .flags_vec (flags_vec),
      .hit       (lk_hit),
      .way       (lk_way),
      .multi     (lk_multi),
      .ppn       (sel_ppn),
      .flags     (sel_flags)
   );

   assign lk_pa          = lk_hit ? {sel_ppn, lk_va[PAGE_BITS-1:0]} : '0;
   assign lk_prot        = sel_flags.prot;
   assign lk_size        = sel_flags.size;
   assign lk_cache       = sel_flags.cache;
   assign lk_dirty       = sel_flags.dirty;
   assign lk_share       = sel_flags.share;
   assign lk_dirty_fault = lk_hit && lk_write && !sel_flags.dirty;

endmodule

// File: rtl/sw_fill_tlb_checker.sv
module sw_fill_tlb_checker #(
   parameter int WAYS  = 4,
   parameter int WAY_W = 2,
   parameter int VPN_W = 20
) (
   input logic             clk,
   input logic             rst_n,
   input logic             load_cmd,
   input logic [VPN_W-1:0] stage_vpn,
   input logic             stage_valid,
   input logic [WAY_W-1:0] repl_way,
   input logic             repl_wr_en,
   input logic [WAY_W-1:0] repl_wr_way,
   input logic             fault_set,
   input logic [WAY_W-1:0] fault_way,
   input logic [VPN_W-1:0] lk_vpn,
   input logic             lk_write,
   input logic             lk_hit,
   input logic [WAY_W-1:0] lk_way,
   input logic             lk_multi,
   input logic             lk_dirty,
   input logic             lk_dirty_fault,
   input logic [WAYS-1:0]  hit_vec
);

   logic seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q <= 1'b0;
      end else if (load_cmd && stage_valid) begin
         seen_q <= 1'b1;
      end
   end

   assert_empty_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_q |-> !lk_hit);

   assert_hit_from_ways_R3: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit == (hit_vec != '0));

   assert_load_visible_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (load_cmd && stage_valid) |=> (lk_vpn != $past(stage_vpn)) || lk_hit);

   assert_load_way_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (load_cmd && stage_valid) |=> (lk_vpn != $past(stage_vpn)) || hit_vec[$past(repl_way)]);

   assert_sw_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      repl_wr_en |=> repl_way == $past(repl_wr_way));

   assert_fault_preload_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_set && !repl_wr_en) |=> repl_way == $past(fault_way));

   assert_field_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!fault_set && !repl_wr_en) |=> $stable(repl_way));

   assert_multi_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      lk_multi == ($countones(hit_vec) > 1));

   assert_lowest_way_R9: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> hit_vec[lk_way] && ((hit_vec & ((WAYS'(1) << lk_way) - WAYS'(1))) == '0));

   assert_dirty_fault_R10: assert property (@(posedge clk) disable iff (!rst_n)
      lk_dirty_fault == (lk_hit && lk_write && !lk_dirty));

endmodule

bind sw_fill_tlb sw_fill_tlb_checker #(
   .WAYS  (WAYS),
   .WAY_W (WAY_W),
   .VPN_W (VPN_W)
) u_checker (
   .clk            (clk),
   .rst_n          (rst_n),
   .load_cmd       (load_cmd),
   .stage_vpn      (stage_vpn),
   .stage_valid    (stage_valid),
   .repl_way       (repl_way),
   .repl_wr_en     (repl_wr_en),
   .repl_wr_way    (repl_wr_way),
   .fault_set      (fault_set),
   .fault_way      (fault_way),
   .lk_vpn         (lk_vpn),
   .lk_write       (lk_write),
   .lk_hit         (lk_hit),
   .lk_way         (lk_way),
   .lk_multi       (lk_multi),
   .lk_dirty       (lk_dirty),
   .lk_dirty_fault (lk_dirty_fault),
   .hit_vec        (hit_vec)
);

// File: tb/sw_fill_tlb_bench.sv
module sw_fill_tlb_bench;
   localparam int VPN_W = 20;
   localparam int PPN_W = 20;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             stg_tag_we = 1'b0;
   logic [VPN_W-1:0] stg_tag_vpn = '0;
   logic             stg_data_we = 1'b0;
   logic [PPN_W-1:0] stg_data_ppn = '0;
   logic [1:0]       stg_data_prot = '0;
   logic             stg_data_size = 1'b0;
   logic             stg_data_cache = 1'b0;
   logic             stg_data_dirty = 1'b0;
   logic             stg_data_share = 1'b0;
   logic             stg_data_valid = 1'b0;
   logic             repl_wr_en = 1'b0;
   logic [1:0]       repl_wr_way = '0;
   logic             fault_set = 1'b0;
   logic [1:0]       fault_way = '0;
   logic [1:0]       repl_way;
   logic             load_cmd = 1'b0;
   logic [31:0]      lk_va = '0;
   logic             lk_write = 1'b0;
   logic             lk_hit;
   logic [1:0]       lk_way;
   logic             lk_multi;
   logic [31:0]      lk_pa;
   logic [1:0]       lk_prot;
   logic             lk_size, lk_cache, lk_dirty, lk_share, lk_dirty_fault;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   sw_fill_tlb u_sw_fill_tlb (
      .clk(clk), .rst_n(rst_n),
      .stg_tag_we(stg_tag_we), .stg_tag_vpn(stg_tag_vpn),
      .stg_data_we(stg_data_we), .stg_data_ppn(stg_data_ppn),
      .stg_data_prot(stg_data_prot), .stg_data_size(stg_data_size),
      .stg_data_cache(stg_data_cache), .stg_data_dirty(stg_data_dirty),
      .stg_data_share(stg_data_share), .stg_data_valid(stg_data_valid),
      .repl_wr_en(repl_wr_en), .repl_wr_way(repl_wr_way),
      .fault_set(fault_set), .fault_way(fault_way), .repl_way(repl_way),
      .load_cmd(load_cmd), .lk_va(lk_va), .lk_write(lk_write),
      .lk_hit(lk_hit), .lk_way(lk_way), .lk_multi(lk_multi), .lk_pa(lk_pa),
      .lk_prot(lk_prot), .lk_size(lk_size), .lk_cache(lk_cache),
      .lk_dirty(lk_dirty), .lk_share(lk_share), .lk_dirty_fault(lk_dirty_fault)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // flags vector = {prot[1:0], size, cache, dirty, share}
   task automatic stage(input logic [19:0] vpn, input logic [19:0] ppn,
                        input logic [5:0] f, input logic v);
      @(negedge clk);
      stg_tag_we = 1'b1; stg_tag_vpn = vpn;
      stg_data_we = 1'b1; stg_data_ppn = ppn; stg_data_valid = v;
      {stg_data_prot, stg_data_size, stg_data_cache, stg_data_dirty, stg_data_share} = f;
      @(negedge clk);
      stg_tag_we = 1'b0; stg_data_we = 1'b0;
   endtask

   task automatic set_way(input logic [1:0] w);
      @(negedge clk);
      repl_wr_en = 1'b1; repl_wr_way = w;
      @(negedge clk);
      repl_wr_en = 1'b0;
   endtask

   task automatic do_load();
      @(negedge clk);
      load_cmd = 1'b1;
      @(negedge clk);
      load_cmd = 1'b0;
   endtask

   task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn,
                       input logic [5:0] f, input logic v, input logic [1:0] w);
      stage(vpn, ppn, f, v);
      set_way(w);
      do_load();
   endtask

   task automatic look(input logic [19:0] vpn, input logic [11:0] off, input logic wr);
      @(negedge clk);
      lk_va = {vpn, off}; lk_write = wr;
      #1;
   endtask

   task automatic t_reset();
      chk("R1 field after reset", repl_way, 0);
      look(20'h12345, 12'h000, 1'b0); chk("R1 miss after reset", lk_hit, 0);
      look(20'h00000, 12'h000, 1'b0); chk("R1 miss zero page", lk_hit, 0);
      do_load();
      look(20'h00000, 12'h000, 1'b0); chk("R1 load of cleared staging", lk_hit, 0);
   endtask

   task automatic t_basic();
      fill(20'h12345, 20'hABCDE, 6'b10_1_1_1_0, 1'b1, 2'd2);
      look(20'h12345, 12'h678, 1'b0);
      chk("R5 hit", lk_hit, 1);
      chk("R5 way", lk_way, 2);
      chk("R8 pa", lk_pa, 32'hABCDE678);
      chk("R8 flags", {lk_prot, lk_size, lk_cache, lk_dirty, lk_share}, 6'b10_1_1_1_0);
      chk("R9 single hit no multi", lk_multi, 0);
      look(20'h22345, 12'h678, 1'b0);
      chk("R2 same set other tag miss", lk_hit, 0);
      chk("R8 pa zero on miss", lk_pa, 0);
      look(20'h12346, 12'h678, 1'b0);
      chk("R2 other set miss", lk_hit, 0);
   endtask

   task automatic t_same_cycle();
      stage(20'h00A01, 20'h0F00D, 6'b01_0_0_1_1, 1'b1);
      set_way(2'd0);
      @(negedge clk);
      load_cmd = 1'b1; lk_va = {20'h00A01, 12'h010}; lk_write = 1'b0;
      #1;
      chk("R4 same cycle sees old", lk_hit, 0);
      @(negedge clk);
      load_cmd = 1'b0;
      #1;
      chk("R4 visible after edge", lk_hit, 1);
      chk("R4 pa after edge", lk_pa, 32'h0F00D010);
   endtask

   task automatic t_invalid();
      fill(20'h0BEEF, 20'h11111, 6'b00_0_1_1_0, 1'b0, 2'd1);
      look(20'h0BEEF, 12'h000, 1'b0); chk("R3 invalid entry misses", lk_hit, 0);
      fill(20'h0BEEF, 20'h11111, 6'b00_0_1_1_0, 1'b1, 2'd1);
      look(20'h0BEEF, 12'h004, 1'b0);
      chk("R3 valid entry hits", lk_hit, 1);
      chk("R3 way", lk_way, 1);
   endtask

   task automatic t_stage_race();
      stage(20'h33301, 20'h22222, 6'b11_0_0_1_0, 1'b1);
      set_way(2'd3);
      @(negedge clk);
      load_cmd = 1'b1; stg_tag_we = 1'b1; stg_tag_vpn = 20'h44401;
      @(negedge clk);
      load_cmd = 1'b0; stg_tag_we = 1'b0;
      look(20'h33301, 12'h000, 1'b0);
      chk("R11 pre-edge staging loaded", lk_hit, 1);
      chk("R11 way", lk_way, 3);
      look(20'h44401, 12'h000, 1'b0);
      chk("R11 racing tag not loaded", lk_hit, 0);
   endtask

   task automatic t_field();
      @(negedge clk);
      repl_wr_en = 1'b1; repl_wr_way = 2'd1; fault_set = 1'b1; fault_way = 2'd3;
      @(negedge clk);
      repl_wr_en = 1'b0; fault_set = 1'b0;
      chk("R6 software wins", repl_way, 1);
      fault_set = 1'b1; fault_way = 2'd2;
      @(negedge clk);
      fault_set = 1'b0;
      chk("R6 fault preload", repl_way, 2);
      repeat (3) @(negedge clk);
      chk("R7 field holds", repl_way, 2);
      stage(20'h55502, 20'h33333, 6'b00_0_0_1_0, 1'b1);
      do_load();
      look(20'h55502, 12'h000, 1'b0);
      chk("R5 load uses preloaded way", lk_way, 2);
   endtask

   task automatic t_multi();
      fill(20'h77707, 20'h44444, 6'b00_0_0_1_0, 1'b1, 2'd3);
      fill(20'h77707, 20'h55555, 6'b00_0_0_1_0, 1'b1, 2'd1);
      look(20'h77707, 12'h000, 1'b0);
      chk("R9 multi flag", lk_multi, 1);
      chk("R9 lowest way", lk_way, 1);
      chk("R9 lowest way data", lk_pa, 32'h55555000);
   endtask

   task automatic t_ways();
      for (int w = 0; w < 4; w++)
         fill(20'h00010 + 20'(w * 32), 20'h60000 + 20'(w), 6'b00_0_0_1_0, 1'b1, 2'(w));
      for (int w = 0; w < 4; w++) begin
         look(20'h00010 + 20'(w * 32), 12'h000, 1'b0);
         chk("R12 way kept", {lk_hit, lk_way}, {1'b1, 2'(w)});
      end
      fill(20'h00090, 20'h6000F, 6'b00_0_0_1_0, 1'b1, 2'd2);
      look(20'h00050, 12'h000, 1'b0); chk("R12 replaced entry gone", lk_hit, 0);
      look(20'h00090, 12'h000, 1'b0); chk("R12 new entry way", {lk_hit, lk_way}, 3'b1_10);
      look(20'h00030, 12'h000, 1'b0); chk("R12 neighbour kept", {lk_hit, lk_way}, 3'b1_01);
   endtask

   task automatic t_dirty();
      look(20'h12345, 12'h000, 1'b1); chk("R10 dirty page write", lk_dirty_fault, 0);
      fill(20'h0ACE0, 20'h77777, 6'b01_0_0_0_0, 1'b1, 2'd0);
      look(20'h0ACE0, 12'h000, 1'b0); chk("R10 clean page read", lk_dirty_fault, 0);
      look(20'h0ACE0, 12'h000, 1'b1); chk("R10 clean page write", lk_dirty_fault, 1);
      look(20'h0DEAD, 12'h000, 1'b1); chk("R10 miss write", lk_dirty_fault, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_basic();
      t_same_cycle();
      t_invalid();
      t_stage_race();
      t_field();
      t_multi();
      t_ways();
      t_dirty();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule